// File: doc/BRIEF.md
# Guarded Rule Scheduler Datapath

This block arbitrates among a fixed set of guarded state-update rules and applies the winning rule's effect to a shared bank of registers. Each rule contributes an explicit condition, a combined readiness bit that stands for the implicit conditions of every method the rule uses, and one proposed next value for every register in the bank. A rule may fire only when both its condition and its readiness bit are high. Each cycle, at most one rule is granted, so the result always equals running the rules one after another.

The grant drives two things. The first is a write enable for each register, formed only from the rules that a static write mask marks as writers of that register. The second is a grant-selected next value for that register. A register that is not written keeps its value. The per-rule fire vector also serves as the enable half of each rule's ready/enable pair toward the modules the rule touches. Proposals are expected to be computed combinationally from the current register outputs, and updates land on the rising clock edge.

Top module: `gsched_top`

## Requirements
- R1: When `rst_n` is low at a rising edge, every register in the bank becomes zero on that edge, whatever rules are enabled.
- R2: `can_fire[i]` is high exactly when both `rule_cond[i]` and `rule_rdy[i]` are high. A rule whose readiness bit is low is never granted.
- R3: `will_fire` has at most one bit set. When any `can_fire` bit is set, the granted rule is the one with the lowest index among the enabled rules.
- R4: When no `can_fire` bit is set, `will_fire` and `reg_we` are all zero and no register changes at the next edge.
- R5: `reg_we[j]` is high exactly when the granted rule i has write-mask bit `WMASK[i*M+j]` set. A register whose enable is low holds its value across the edge.
- R6: For a register whose enable is high, `reg_next[j*W +: W]` shows the granted rule's proposal `prop_val[(i*M+j)*W +: W]` in the same cycle, and `reg_q[j*W +: W]` takes that value at the next rising edge. With the enable low, `reg_next` equals the current register value.
- R7: Proposals from rules that are not granted, and proposals from the granted rule for registers outside its write mask, have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the register bank |
| rule_cond | input | N | Explicit condition of each rule |
| rule_rdy | input | N | Combined implicit readiness of the methods each rule uses |
| prop_val | input | N*M*W | Proposed values; rule i, register j at bits (i*M+j)*W upward |
| can_fire | output | N | Rules whose full predicate holds |
| will_fire | output | N | Granted rule, one-hot or zero |
| reg_we | output | M | Write enable of each register |
| reg_next | output | M*W | Value each register will hold after the next edge (reset aside) |
| reg_q | output | M*W | Current register bank contents |

## Verification
The predicate, grant, enable and next-value outputs are combinational, so they are due in the same cycle as the stimulus. The bench drives each vector on a falling edge and samples these outputs one nanosecond later. The register bank result is due one rising edge later. The driver pushes the reference model's expected bank into a queue, and a monitor on the following falling edge pops it and compares it with `reg_q`. That edge comes after exactly one rising edge, so each comparison lines up with the vector that caused it.

// File: rtl/gsched_pkg.sv
package gsched_pkg;

    localparam int GS_MAX_RULES = 8;

    // Bit offset of the proposal that rule r makes for register j.
    function automatic int prop_base(input int r, input int j, input int m, input int w);
        return (r * m + j) * w;
    endfunction

endpackage

// File: rtl/gsched_prio_enc.sv
module gsched_prio_enc #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    // Walk from the highest index down so the lowest enabled index wins.
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/gsched_reg_slice.sv
module gsched_reg_slice #(
    parameter int           N   = 4,
    parameter int           W   = 8,
    parameter logic [N-1:0] COL = '1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   grant,
    input  logic [N*W-1:0] props,
    output logic           we,
    output logic [W-1:0]   d_val,
    output logic [W-1:0]   q
);

    logic [N-1:0] hit;
    logic [W-1:0] sel_val;

    assign hit = grant & COL;
    assign we  = |hit;

    // AND-OR selection: the grant is one-hot or zero.
    always_comb begin
        sel_val = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                sel_val = sel_val | props[i*W +: W];
            end
        end
    end

    assign d_val = we ? sel_val : q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= sel_val;
        end
    end

endmodule

// File: rtl/gsched_top.sv
module gsched_top
    import gsched_pkg::*;
#(
    parameter int             N     = 4,
    parameter int             M     = 4,
    parameter int             W     = 8,
    parameter logic [N*M-1:0] WMASK = 16'h9C23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     rule_cond,
    input  logic [N-1:0]     rule_rdy,
    input  logic [N*M*W-1:0] prop_val,
    output logic [N-1:0]     can_fire,
    output logic [N-1:0]     will_fire,
    output logic [M-1:0]     reg_we,
    output logic [M*W-1:0]   reg_next,
    output logic [M*W-1:0]   reg_q
);

    localparam int PROP_BITS = N * W;

    // Column j of the write mask: which rules write register j.
    function automatic logic [N-1:0] writers_of(input int j);
        logic [N-1:0] col;
        for (int i = 0; i < N; i++) begin
            col[i] = WMASK[i*M + j];
        end
        return col;
    endfunction

    // Full predicate: explicit condition AND implicit readiness.
    assign can_fire = rule_cond & rule_rdy;

    gsched_prio_enc #(.N(N)) u_prio (
        .req (can_fire),
        .gnt (will_fire)
    );

    for (genvar j = 0; j < M; j++) begin : g_reg
        logic [PROP_BITS-1:0] props_j;

        for (genvar i = 0; i < N; i++) begin : g_gather
            assign props_j[i*W +: W] = prop_val[prop_base(i, j, M, W) +: W];
        end

        gsched_reg_slice #(
            .N   (N),
            .W   (W),
            .COL (writers_of(j))
        ) u_slice (
            .clk   (clk),
            .rst_n (rst_n),
            .grant (will_fire),
            .props (props_j),
            .we    (reg_we[j]),
            .d_val (reg_next[j*W +: W]),
            .q     (reg_q[j*W +: W])
        );
    end

endmodule

// File: rtl/gsched_chk.sv
module gsched_chk #(
    parameter int N = 4,
    parameter int M = 4,
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   rule_cond,
    input logic [N-1:0]   rule_rdy,
    input logic [N-1:0]   can_fire,
    input logic [N-1:0]   will_fire,
    input logic [M-1:0]   reg_we,
    input logic [M*W-1:0] reg_next,
    input logic [M*W-1:0] reg_q
);

    assert_grant_guarded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (will_fire & ~(rule_cond & rule_rdy)) == '0);

    assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(will_fire));

    assert_grant_within_can_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (will_fire & ~can_fire) == '0);

    assert_some_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (can_fire != '0) |-> (will_fire != '0));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (can_fire == '0) |=> $stable(reg_q));

    assert_idle_no_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (will_fire == '0) |-> (reg_we == '0));

    for (genvar j = 0; j < M; j++) begin : g_regchk
        assert_hold_unwritten_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !reg_we[j] |=> $stable(reg_q[j*W +: W]));

        assert_load_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
            reg_we[j] |=> (reg_q[j*W +: W] == $past(reg_next[j*W +: W])));
    end

endmodule

bind gsched_top gsched_chk #(.N(N), .M(M), .W(W)) u_gsched_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rule_cond (rule_cond),
    .rule_rdy  (rule_rdy),
    .can_fire  (can_fire),
    .will_fire (will_fire),
    .reg_we    (reg_we),
    .reg_next  (reg_next),
    .reg_q     (reg_q)
);

// File: tb/test_gsched_top.sv
`timescale 1ns/1ps
module test_gsched_top;

    localparam int             N     = 4;
    localparam int             M     = 4;
    localparam int             W     = 8;
    localparam logic [N*M-1:0] WMASK = 16'h9C23;

    typedef struct {
        logic [M*W-1:0] q;
        bit             rst;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     rule_cond = '0;
    logic [N-1:0]     rule_rdy = '0;
    logic [N*M*W-1:0] prop_val = '0;
    logic [N-1:0]     can_fire;
    logic [N-1:0]     will_fire;
    logic [M-1:0]     reg_we;
    logic [M*W-1:0]   reg_next;
    logic [M*W-1:0]   reg_q;

    logic [M*W-1:0] mdl = '0;
    exp_t           sb[$];
    int             vecs = 0;
    int             miss = 0;
    bit             done = 1'b0;

    always #4 clk = ~clk;

    gsched_top #(.N(N), .M(M), .W(W), .WMASK(WMASK)) i_gsched_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .rule_cond (rule_cond),
        .rule_rdy  (rule_rdy),
        .prop_val  (prop_val),
        .can_fire  (can_fire),
        .will_fire (will_fire),
        .reg_we    (reg_we),
        .reg_next  (reg_next),
        .reg_q     (reg_q)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply one vector, check the combinational results, queue the bank result.
    task automatic apply(input logic [N-1:0] c, input logic [N-1:0] r, input bit do_rst);
        logic [N-1:0]   ecan;
        logic [N-1:0]   ewill;
        logic [M-1:0]   ewe;
        logic [M*W-1:0] enext;
        exp_t           item;
        @(negedge clk);
        rule_cond = c;
        rule_rdy  = r;
        rst_n     = !do_rst;
        for (int k = 0; k < N*M; k++) prop_val[k*W +: W] = W'($urandom);
        #1;
        ecan  = c & r;
        ewill = '0;
        for (int i = 0; i < N; i++) begin
            if (ecan[i] && ewill == '0) ewill[i] = 1'b1;
        end
        ewe   = '0;
        enext = mdl;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < M; j++) begin
                if (ewill[i] && WMASK[i*M + j]) begin
                    ewe[j] = 1'b1;
                    enext[j*W +: W] = prop_val[(i*M + j)*W +: W];
                end
            end
        end
        check("R2 can_fire", 64'(can_fire), 64'(ecan));
        check("R3 will_fire priority", 64'(will_fire), 64'(ewill));
        check("R5 reg_we", 64'(reg_we), 64'(ewe));
        if (!do_rst) check("R6 reg_next", 64'(reg_next), 64'(enext));
        mdl = do_rst ? '0 : enext;
        item.q   = mdl;
        item.rst = do_rst;
        sb.push_back(item);
    endtask

    // Monitor: one falling edge after the driver, i.e. after exactly one rising edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            if (e.rst) check("R1 reset reg_q", 64'(reg_q), 64'(e.q));
            else       check("R4/R5/R6/R7 reg_q", 64'(reg_q), 64'(e.q));
        end
    end

    initial begin
        apply(4'b1111, 4'b1111, 1'b1);      // R1 reset wins over active rules
        apply(4'b0000, 4'b0000, 1'b1);
        apply(4'b0000, 4'b0000, 1'b0);      // R4 nothing enabled
        for (int i = 0; i < N; i++) begin   // each rule alone, R6 and R7
            apply(4'(1 << i), 4'b1111, 1'b0);
        end
        apply(4'b1111, 4'b1111, 1'b0);      // R3 rule 0 wins
        apply(4'b1110, 4'b1111, 1'b0);      // R3 rule 1 wins
        apply(4'b1111, 4'b0110, 1'b0);      // R2 readiness masks rules 0 and 3
        apply(4'b1001, 4'b0110, 1'b0);      // R2/R4 conditions without readiness
        apply(4'b1100, 4'b1111, 1'b0);      // R7 rule 3 proposals ignored
        apply(4'b1000, 4'b1111, 1'b0);
        for (int n = 0; n < 300; n++) begin
            apply(4'($urandom), 4'($urandom), ($urandom % 40) == 0);
        end
        apply(4'b0000, 4'b0000, 1'b0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miss++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

endmodule